// File: doc/BRIEF.md
# Multi-Format Serial Line Encoder

This block turns a serial bit stream into a line waveform in one of eight selectable codings: seven real line codes and one reserved code. Time is counted in half-bit ticks. An input strobe, `half_tick`, marks each half of a bit period. The first strobe after reset, and every second strobe after that, opens a new bit. On that strobe the encoder samples the data bit and the format select. It then emits the first half-level, and on the next strobe it emits the second half-level.

Every output level is a small signed code: +1, 0 or -1. Two-level codes use 0 and +1 only. Three-level codes use all three values, so the code stands in for an analog bipolar driver. A bias-force input pulls any half-bit to level 0.

Three pieces of history are updated by every bit, whatever format is selected:
- the differential NRZ level;
- the biphase pair order;
- the polarity of the next alternating mark.

Because of this, the stream stays continuous when the format is switched at a bit boundary.

Top module: `line_encoder`

## Requirements
- R1: After reset `line_lvl` is 0 and `line_first` is 0, and the next `half_tick` starts a bit.
- R2: The output changes only in the clock after a `half_tick` and holds otherwise. `line_first` toggles on every tick, and is 1 while a first half is shown. `data_in` and `fmt_sel` are sampled only on the tick that starts a bit, so their values on the second-half tick have no effect.
- R3: Format 0 (level NRZ): both halves are +1 for a 1 and 0 for a 0. Two-level formats 0 to 4 never output -1.
- R4: Format 1 (differential NRZ): a 1 inverts the held level and a 0 keeps it. Both halves carry the new level, and the held level is low after reset.
- R5: Format 2 (return-to-zero): the first half carries the data (+1 or 0) and the second half is 0.
- R6: Format 3 (split-phase): a 0 is sent as 0 then +1, and a 1 as +1 then 0.
- R7: Format 4 (mark biphase): each bit is a complementary pair. A 0 repeats the previous pair order and a 1 reverses it. The order before the first bit is low-then-high.
- R8: Format 5 (return-to-bias): the first half is +1 for a 1 and -1 for a 0, and the second half is 0.
- R9: Format 6 (alternate mark inversion): a 0 gives 0 in both halves. A 1 gives ±1 in the first half, opposite in sign to the previous 1, then 0. The first 1 after reset is +1.
- R10: `bias_force` sampled high on a tick makes that half-bit 0, while all format history still advances with the bit.
- R11: History for formats 1, 4 and 6 advances on every bit under any format, so after a switch the code continues from all bits sent since reset.
- R12: Format 7 is reserved and gives 0 in both halves. Levels are coded two's complement in `LVL_W` bits: +1 is 1, 0 is 0, -1 is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_tick | input | 1 | Half-bit strobe, one clock wide |
| data_in | input | 1 | Serial data bit, sampled at bit start |
| fmt_sel | input | 3 | Format code 0..7, sampled at bit start |
| bias_force | input | 1 | Forces the current half-bit to level 0 |
| line_lvl | output | LVL_W | Signed level code of the line |
| line_first | output | 1 | High while the first half of a bit is shown |

## Verification
The stimulus aims at history-dependent cases: runs of equal bits under differential NRZ and mark biphase, and alternate-mark polarity across long zero runs. A design that reset its history wrongly, or updated it only while its own format was selected, would send the wrong level or pair order after a format switch. Data and format are changed on the second-half tick, so a design that resampled mid-bit would corrupt the second half. Bias-force is pulsed on single halves of alternate-mark bits, so that skipping the polarity flip on a forced mark shows up as a repeated sign on the next mark.

// File: rtl/lenc_pkg.sv
package lenc_pkg;

   typedef enum logic [2:0] {
      FMT_NRZL  = 3'd0,
      FMT_NRZM  = 3'd1,
      FMT_RZ    = 3'd2,
      FMT_MAN   = 3'd3,
      FMT_BMARK = 3'd4,
      FMT_RB    = 3'd5,
      FMT_AMI   = 3'd6,
      FMT_RSVD  = 3'd7
   } fmt_e;

   typedef enum logic [1:0] {
      LV_ZERO = 2'b00,
      LV_POS  = 2'b01,
      LV_NEG  = 2'b11
   } lvl_e;

   typedef struct packed {
      lvl_e first;
      lvl_e second;
   } pair_t;

   function automatic lvl_e uni_lvl(input logic b);
      return b ? LV_POS : LV_ZERO;
   endfunction

endpackage

// File: rtl/lenc_timing.sv
module lenc_timing
   import lenc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic half_tick,
   input  fmt_e fmt_in,
   output logic first_go,
   output logic second_go,
   output logic phase_q,
   output fmt_e fmt_q
);

   assign first_go  = half_tick & ~phase_q;
   assign second_go = half_tick &  phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= 1'b0;
         fmt_q   <= FMT_NRZL;
      end else begin
         if (half_tick) phase_q <= ~phase_q;
         if (first_go)  fmt_q   <= fmt_in;
      end
   end

endmodule

// File: rtl/lenc_history.sv
module lenc_history #(
   parameter bit NRZM_INIT = 1'b0,
   parameter bit BM_INIT   = 1'b0,
   parameter bit AMI_INIT  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   input  logic d,
   output logic nrzm_new,
   output logic bm_new,
   output logic ami_pos
);

   logic nrzm_q, bm_q, ami_q;

   assign nrzm_new = nrzm_q ^ d;
   assign bm_new   = bm_q ^ d;
   assign ami_pos  = ami_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nrzm_q <= NRZM_INIT;
         bm_q   <= BM_INIT;
         ami_q  <= AMI_INIT;
      end else if (adv) begin
         nrzm_q <= nrzm_new;
         bm_q   <= bm_new;
         ami_q  <= ami_q ^ d;
      end
   end

endmodule

// File: rtl/lenc_bipolar.sv
module lenc_bipolar
   import lenc_pkg::*;
(
   input  logic en,
   input  logic bit_in,
   output lvl_e lvl
);

   always_comb begin
      if (!en)        lvl = LV_ZERO;
      else if (bit_in) lvl = LV_POS;
      else            lvl = LV_NEG;
   end

endmodule

// File: rtl/lenc_symbol.sv
module lenc_symbol
   import lenc_pkg::*;
#(
   parameter bit RSVD_BIAS = 1'b1
) (
   input  fmt_e  fmt,
   input  logic  d,
   input  logic  nrzm_new,
   input  logic  bm_new,
   input  lvl_e  rb_lvl,
   input  lvl_e  ami_lvl,
   output pair_t sym
);

   always_comb begin
      sym = '{first: LV_ZERO, second: LV_ZERO};
      unique case (fmt)
         FMT_NRZL:  sym = '{first: uni_lvl(d),        second: uni_lvl(d)};
         FMT_NRZM:  sym = '{first: uni_lvl(nrzm_new), second: uni_lvl(nrzm_new)};
         FMT_RZ:    sym = '{first: uni_lvl(d),        second: LV_ZERO};
         FMT_MAN:   sym = '{first: uni_lvl(d),        second: uni_lvl(~d)};
         FMT_BMARK: sym = '{first: uni_lvl(bm_new),   second: uni_lvl(~bm_new)};
         FMT_RB:    sym = '{first: rb_lvl,            second: LV_ZERO};
         FMT_AMI:   sym = '{first: ami_lvl,           second: LV_ZERO};
         FMT_RSVD:  sym = RSVD_BIAS ? '{first: LV_ZERO, second: LV_ZERO}
                                    : '{first: uni_lvl(d), second: uni_lvl(d)};
         default:   sym = '{first: LV_ZERO, second: LV_ZERO};
      endcase
   end

endmodule

// File: rtl/line_encoder.sv
module line_encoder
   import lenc_pkg::*;
#(
   parameter int LVL_W     = 2,
   parameter bit NRZM_INIT = 1'b0,
   parameter bit BM_INIT   = 1'b0,
   parameter bit AMI_INIT  = 1'b1,
   parameter bit RSVD_BIAS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             half_tick,
   input  logic             data_in,
   input  logic [2:0]       fmt_sel,
   input  logic             bias_force,
   output logic [LVL_W-1:0] line_lvl,
   output logic             line_first
);

   localparam int NUM_BIP = 2;
   localparam int BIP_RB  = 0;
   localparam int BIP_AMI = 1;

   if (LVL_W < 2) begin : g_bad_width
      $error("line_encoder: LVL_W must be at least 2");
   end

   fmt_e  fmt_now, fmt_lat;
   logic  first_go, second_go, phase_q;
   logic  nrzm_new, bm_new, ami_pos;
   logic  bip_en  [NUM_BIP];
   logic  bip_bit [NUM_BIP];
   lvl_e  bip_lvl [NUM_BIP];
   pair_t sym;
   lvl_e  out_q, second_q;

   assign fmt_now = fmt_e'(fmt_sel);

   lenc_timing u_timing (
      .clk       (clk),
      .rst_n     (rst_n),
      .half_tick (half_tick),
      .fmt_in    (fmt_now),
      .first_go  (first_go),
      .second_go (second_go),
      .phase_q   (phase_q),
      .fmt_q     (fmt_lat)
   );

   lenc_history #(
      .NRZM_INIT (NRZM_INIT),
      .BM_INIT   (BM_INIT),
      .AMI_INIT  (AMI_INIT)
   ) u_history (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (first_go),
      .d        (data_in),
      .nrzm_new (nrzm_new),
      .bm_new   (bm_new),
      .ami_pos  (ami_pos)
   );

   // return-to-bias: always enabled, data picks sign
   // alternate mark: enabled by a mark, history picks sign
   assign bip_en[BIP_RB]   = 1'b1;
   assign bip_bit[BIP_RB]  = data_in;
   assign bip_en[BIP_AMI]  = data_in;
   assign bip_bit[BIP_AMI] = ami_pos;

   for (genvar g = 0; g < NUM_BIP; g++) begin : g_bip
      lenc_bipolar u_bip (
         .en     (bip_en[g]),
         .bit_in (bip_bit[g]),
         .lvl    (bip_lvl[g])
      );
   end

   lenc_symbol #(
      .RSVD_BIAS (RSVD_BIAS)
   ) u_symbol (
      .fmt      (fmt_now),
      .d        (data_in),
      .nrzm_new (nrzm_new),
      .bm_new   (bm_new),
      .rb_lvl   (bip_lvl[BIP_RB]),
      .ami_lvl  (bip_lvl[BIP_AMI]),
      .sym      (sym)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q    <= LV_ZERO;
         second_q <= LV_ZERO;
      end else if (first_go) begin
         out_q    <= bias_force ? LV_ZERO : sym.first;
         second_q <= sym.second;
      end else if (second_go) begin
         out_q    <= bias_force ? LV_ZERO : second_q;
      end
   end

   always_comb begin
      line_lvl      = {LVL_W{out_q[1]}};
      line_lvl[1:0] = out_q;
   end

   assign line_first = phase_q;

endmodule

// File: rtl/lenc_checker.sv
module lenc_checker
   import lenc_pkg::*;
#(
   parameter int LVL_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             half_tick,
   input logic [2:0]       fmt_sel,
   input logic             bias_force,
   input logic [LVL_W-1:0] line_lvl,
   input logic             line_first,
   input fmt_e             fmt_lat
);

   localparam logic [LVL_W-1:0] L_ZERO = '0;
   localparam logic [LVL_W-1:0] L_POS  = LVL_W'(1);
   localparam logic [LVL_W-1:0] L_NEG  = '1;

   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !half_tick |=> $stable(line_lvl) && $stable(line_first)); // R2

   AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      half_tick |=> line_first != $past(line_first)); // R2

   AST_FORCE_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
      half_tick && bias_force |=> line_lvl == L_ZERO); // R10

   AST_RETURN_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
      half_tick && line_first &&
      (fmt_lat inside {FMT_RZ, FMT_RB, FMT_AMI, FMT_RSVD}) |=> line_lvl == L_ZERO); // R5

   AST_UNIPOLAR: assert property (@(posedge clk) disable iff (!rst_n)
      half_tick && ((!line_first && fmt_sel <= 3'd4) ||
                    (line_first && fmt_lat <= FMT_BMARK)) |=> line_lvl != L_NEG); // R3

   AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      line_lvl == L_ZERO || line_lvl == L_POS || line_lvl == L_NEG); // R12

endmodule

bind line_encoder lenc_checker #(.LVL_W(LVL_W)) u_lenc_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .half_tick  (half_tick),
   .fmt_sel    (fmt_sel),
   .bias_force (bias_force),
   .line_lvl   (line_lvl),
   .line_first (line_first),
   .fmt_lat    (fmt_lat)
);

// File: tb/line_encoder_bench.sv
module line_encoder_bench;

   localparam int CLK_PERIOD = 10;
   localparam int LVL_W      = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             half_tick = 1'b0;
   logic             data_in = 1'b0;
   logic [2:0]       fmt_sel = 3'd0;
   logic             bias_force = 1'b0;
   logic [LVL_W-1:0] line_lvl;
   logic             line_first;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   int    exp_lvl_q[$];
   bit    exp_first_q[$];
   string exp_tag_q[$];

   bit m_nrzm = 1'b0;
   bit m_bm   = 1'b0;
   bit m_ami  = 1'b1;

   always #(CLK_PERIOD/2) clk = ~clk;

   line_encoder #(.LVL_W(LVL_W)) u_line_encoder (
      .clk        (clk),
      .rst_n      (rst_n),
      .half_tick  (half_tick),
      .data_in    (data_in),
      .fmt_sel    (fmt_sel),
      .bias_force (bias_force),
      .line_lvl   (line_lvl),
      .line_first (line_first)
   );

   task automatic check(input string tag, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // one bit: first-half tick, then second-half tick with data/format scrambled
   task automatic send_bit(input int fmt, input bit d, input bit dis_a, input bit dis_b,
                           input int fmt_mid, input string tag);
      int f, s;
      bit nn, bb;
      nn = m_nrzm ^ d;
      bb = m_bm ^ d;
      case (fmt)
         0: begin f = d;  s = d;  end
         1: begin f = nn; s = nn; end
         2: begin f = d;  s = 0;  end
         3: begin f = d;  s = d ? 0 : 1; end
         4: begin f = bb; s = bb ? 0 : 1; end
         5: begin f = d ? 1 : -1; s = 0; end
         6: begin f = d ? (m_ami ? 1 : -1) : 0; s = 0; end
         default: begin f = 0; s = 0; end
      endcase
      m_nrzm = nn;
      m_bm   = bb;
      if (d) m_ami = ~m_ami;
      if (dis_a) f = 0;
      if (dis_b) s = 0;
      exp_lvl_q.push_back(f); exp_first_q.push_back(1'b1); exp_tag_q.push_back(tag);
      exp_lvl_q.push_back(s); exp_first_q.push_back(1'b0); exp_tag_q.push_back(tag);
      @(negedge clk);
      data_in = d; fmt_sel = 3'(fmt); bias_force = dis_a; half_tick = 1'b1;
      @(negedge clk);
      half_tick = 1'b0; data_in = ~d; fmt_sel = 3'(fmt_mid);
      @(negedge clk);
      bias_force = dis_b; half_tick = 1'b1;
      @(negedge clk);
      half_tick = 1'b0; bias_force = 1'b0;
   endtask

   task automatic send_pattern(input int fmt, input logic [9:0] pat, input string tag);
      for (int i = 9; i >= 0; i--) send_bit(fmt, pat[i], 1'b0, 1'b0, (fmt + 3) % 8, tag);
   endtask

   // monitor: compare after every tick, sampled at the following falling edge
   initial begin
      forever begin
         @(posedge clk);
         if (rst_n && half_tick) begin
            @(negedge clk);
            if (exp_lvl_q.size() == 0) begin
               checks++; fails++;
               $display("FAIL R2 unexpected tick: actual output %0d expected none", $signed(line_lvl));
            end else begin
               int    el;
               bit    ef;
               string et;
               el = exp_lvl_q.pop_front();
               ef = exp_first_q.pop_front();
               et = exp_tag_q.pop_front();
               check(et, int'($signed(line_lvl)), el, "level");
               check("R2", int'(line_first), int'(ef), "half flag");
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [LVL_W-1:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", int'($signed(line_lvl)), 0, "reset level");
      check("R1", int'(line_first), 0, "reset half flag");

      // R3 level NRZ
      send_pattern(0, 10'b1011001110, "R3");
      // R2 hold without tick
      held = line_lvl;
      repeat (4) @(negedge clk);
      check("R2", int'(line_lvl), int'(held), "hold without tick");
      // R4 differential NRZ, R5 RZ, R6 split-phase, R7 mark biphase
      send_pattern(1, 10'b1100010111, "R4");
      send_pattern(2, 10'b0110100111, "R5");
      send_pattern(3, 10'b1001110001, "R6");
      send_pattern(4, 10'b0001101111, "R7");
      // R8 return-to-bias, R9 alternate mark with zero runs
      send_pattern(5, 10'b1010011100, "R8");
      send_pattern(6, 10'b1000011011, "R9");
      // R12 reserved code
      send_pattern(7, 10'b1111010000, "R12");
      // R10 forcing bias on single halves of marks
      send_bit(6, 1'b1, 1'b1, 1'b0, 0, "R10");
      send_bit(6, 1'b1, 1'b0, 1'b0, 0, "R10");
      send_bit(3, 1'b1, 1'b0, 1'b1, 5, "R10");
      send_bit(4, 1'b0, 1'b1, 1'b1, 2, "R10");
      send_bit(4, 1'b1, 1'b0, 1'b0, 2, "R10");
      // R11 format switching at bit boundaries keeps history
      send_bit(1, 1'b1, 1'b0, 1'b0, 6, "R11");
      send_bit(6, 1'b1, 1'b0, 1'b0, 1, "R11");
      send_bit(0, 1'b1, 1'b0, 1'b0, 4, "R11");
      send_bit(4, 1'b1, 1'b0, 1'b0, 6, "R11");
      send_bit(6, 1'b0, 1'b0, 1'b0, 4, "R11");
      send_bit(1, 1'b0, 1'b0, 1'b0, 6, "R11");
      send_bit(6, 1'b1, 1'b0, 1'b0, 1, "R11");
      send_bit(4, 1'b0, 1'b0, 1'b0, 1, "R11");
      repeat (3) @(negedge clk);
      check("R2", exp_lvl_q.size(), 0, "scoreboard drained");
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule